// File: doc/BRIEF.md
# Queue Head Overlay Unit

This block runs the overlay step of a USB 2.0 host controller's asynchronous schedule. When the schedule moves a queue head onto a new transfer descriptor, the descriptor's words are presented together with a single-cycle `ovl_go` strobe. On the next clock edge the block rewrites the queue head's overlay area. Each field follows its own rule. Most fields are copied. The data toggle and the ping-state bit can be kept from the previous overlay. The split frame tag is cleared. The NAK retry counter is reloaded, and reserved bits are forced to zero.

Between overlays the block keeps the NAK retry counter current. The counter lives in bits 4:1 of the alternate-link word. It counts down on each NAK or NYET response and stops at zero. It reloads from the endpoint's reload value on an overlay or on the first pass after an asynchronous list restart. A flag reports when the counter is zero, so the schedule can skip the queue head.

When an overlay retires the previous transfer, the previous error counter is handed out so it can be written back to the retiring descriptor. Any update to the overlay state raises a write-back strobe. The overlay words stay held inside the block and drive the outputs at all times.

Top module: `qh_overlay_unit`

## Requirements
- R1: On an overlay, the token bits 30:8 are copied from the descriptor token. These bits hold total bytes (30:16), interrupt-on-complete (15), current page (14:12), error counter (11:10) and packet id (9:8). Token bits 7:1 read as zero. Without an overlay the token does not change.
- R2: On an overlay, token bit 31 (data toggle) takes the descriptor's bit 31 when `ep_dtc` is 1. When `ep_dtc` is 0, the bit keeps its previous overlay value.
- R3: On an overlay, token bit 0 (ping state) keeps its previous value when `ep_eps` equals 2'b10 (high speed). For any other speed code it takes the descriptor's bit 0.
- R4: Buffer page words are 32 bits each, with page k at `qtd_bufs`/`ovl_bufs` bits 32k+31:32k. Page 0 is copied whole, including its 12-bit offset in bits 11:0. Page 1 copies bits 31:12 and zeroes bits 11:0. Page 2 copies bits 31:12 and the byte count in bits 11:5, and zeroes the frame tag in bits 4:0.
- R5: On an overlay, the next-link word copies bits 31:5 and the terminate bit 0, with bits 4:1 zero. The alternate-link word copies bits 31:5 and bit 0, and bits 4:1 become `ep_rl`.
- R6: With no overlay or reload pending, `nak_resp` lowers the NAK counter (`ovl_alt[4:1]`) by one. At zero the counter stays at zero. With no strobe, the counter holds.
- R7: `nak_zero` is 1 exactly when the NAK counter is zero.
- R8: `list_restart` without an overlay loads `ep_rl` into the NAK counter, and takes priority over `nak_resp`.
- R9: When `ovl_go` arrives in the same cycle as `nak_resp` or `list_restart`, the counter takes `ep_rl` and the NAK is dropped.
- R10: The cycle after `ovl_go`, `retire_valid` is 1 and `retire_cerr` holds token bits 11:10 as they stood before the overlay. At all other times `retire_valid` is 0.
- R11: `wb_valid` is 1 in the cycle after any `ovl_go`, `list_restart` or `nak_resp`, and 0 otherwise. The outputs show the new words in that same cycle.
- R12: After reset all overlay words are zero, `nak_zero` is 1, and `wb_valid` and `retire_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ovl_go | input | 1 | Overlay strobe, one cycle |
| list_restart | input | 1 | First-pass reload after an asynchronous list restart |
| nak_resp | input | 1 | A transaction got a NAK or NYET |
| ep_rl | input | 4 | NAK counter reload value |
| ep_dtc | input | 1 | 1: data toggle comes from the descriptor |
| ep_eps | input | 2 | Endpoint speed code, 2'b10 = high speed |
| qtd_next | input | 32 | Descriptor next-link word |
| qtd_alt | input | 32 | Descriptor alternate-link word |
| qtd_token | input | 32 | Descriptor token word |
| qtd_bufs | input | 32*NPAGE | Descriptor buffer page words |
| ovl_next | output | 32 | Overlay next-link word |
| ovl_alt | output | 32 | Overlay alternate-link word with NAK counter |
| ovl_token | output | 32 | Overlay token word |
| ovl_bufs | output | 32*NPAGE | Overlay buffer page words |
| nak_zero | output | 1 | NAK counter is zero |
| wb_valid | output | 1 | Overlay state was updated last cycle |
| retire_valid | output | 1 | Retiring error counter is valid |
| retire_cerr | output | 2 | Error counter of the retiring transfer |

## Verification
Assertions check on every cycle that the interrupt flag follows the descriptor and that the frame tag clears. They also check that the data toggle and ping bits are kept under their selecting conditions, and that reserved link bits stay zero. Further cycle checks cover counter decrement, saturation, reload and overlay priority, the retire hand-off of the old error counter, and the write-back strobe. Only the bench's scenarios show that whole words match field by field. They also show that the zero flag tracks a counter driven down through long NAK runs, and that preserved bits carry values set by earlier low-speed or toggle-replacing overlays.

// File: rtl/qho_pkg.sv
package qho_pkg;
   localparam int WORD_W    = 32;
   localparam int NAK_W     = 4;
   localparam int NAK_LSB   = 1;
   localparam int LINK_LSB  = 5;
   localparam int PAGE_LSB  = 12;
   localparam int TAG_W     = 5;
   localparam int TOK_DT    = 31;
   localparam int TOK_IOC   = 15;
   localparam int TOK_PING  = 0;
   localparam int CERR_HI   = 11;
   localparam int CERR_LO   = 10;
   localparam int CERR_W    = CERR_HI - CERR_LO + 1;
   localparam int COPY_HI   = 30;
   localparam int COPY_LO   = 8;
   localparam int RSV_W     = COPY_LO - 1;

   typedef enum logic [1:0] {
      SPD_FULL = 2'b00,
      SPD_LOW  = 2'b01,
      SPD_HIGH = 2'b10,
      SPD_RSVD = 2'b11
   } ep_speed_e;
endpackage

// File: rtl/qho_token_merge.sv
module qho_token_merge
   import qho_pkg::*;
#(
   parameter logic [1:0] HS_EPS = SPD_HIGH
) (
   input  logic [WORD_W-1:0] cur_tok,
   input  logic [WORD_W-1:0] src_tok,
   input  logic              dt_from_src,
   input  logic [1:0]        speed,
   output logic [WORD_W-1:0] new_tok
);
   logic dt_bit;
   logic ping_bit;

   always_comb begin
      dt_bit   = dt_from_src ? src_tok[TOK_DT] : cur_tok[TOK_DT];
      ping_bit = (speed == HS_EPS) ? cur_tok[TOK_PING] : src_tok[TOK_PING];
      new_tok  = {dt_bit, src_tok[COPY_HI:COPY_LO], {RSV_W{1'b0}}, ping_bit};
   end
endmodule

// File: rtl/qho_page_merge.sv
module qho_page_merge
   import qho_pkg::*;
#(
   parameter int IDX = 0
) (
   input  logic [WORD_W-1:0] src_page,
   output logic [WORD_W-1:0] new_page
);
   generate
      if (IDX == 0) begin : g_offset_page
         assign new_page = src_page;
      end else if (IDX == 2) begin : g_tag_page
         assign new_page = {src_page[WORD_W-1:TAG_W], {TAG_W{1'b0}}};
      end else begin : g_plain_page
         assign new_page = {src_page[WORD_W-1:PAGE_LSB], {PAGE_LSB{1'b0}}};
      end
   endgenerate
endmodule

// File: rtl/qho_nak_ctr.sv
module qho_nak_ctr
   import qho_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ovl_go,
   input  logic             reload_go,
   input  logic             nak_hit,
   input  logic [NAK_W-1:0] rl,
   output logic [NAK_W-1:0] cnt,
   output logic             zero
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (ovl_go || reload_go) begin
         cnt <= rl;
      end else if (nak_hit && (cnt != '0)) begin
         cnt <= cnt - 1'b1;
      end
   end

   assign zero = (cnt == '0);

   assert_nak_dec_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nak_hit && !ovl_go && !reload_go && cnt != '0) |=> cnt == NAK_W'($past(cnt) - 1'b1));
   assert_nak_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (nak_hit && !ovl_go && !reload_go && cnt == '0) |=> cnt == '0);
   assert_nak_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!nak_hit && !ovl_go && !reload_go) |=> $stable(cnt));
   assert_restart_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (reload_go && !ovl_go) |=> cnt == $past(rl));
   assert_overlay_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_go |=> cnt == $past(rl));
endmodule

// File: rtl/qh_overlay_unit.sv
module qh_overlay_unit
   import qho_pkg::*;
#(
   parameter int         NPAGE  = 3,
   parameter logic [1:0] HS_EPS = SPD_HIGH
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ovl_go,
   input  logic                    list_restart,
   input  logic                    nak_resp,
   input  logic [NAK_W-1:0]        ep_rl,
   input  logic                    ep_dtc,
   input  logic [1:0]              ep_eps,
   input  logic [WORD_W-1:0]       qtd_next,
   input  logic [WORD_W-1:0]       qtd_alt,
   input  logic [WORD_W-1:0]       qtd_token,
   input  logic [NPAGE*WORD_W-1:0] qtd_bufs,
   output logic [WORD_W-1:0]       ovl_next,
   output logic [WORD_W-1:0]       ovl_alt,
   output logic [WORD_W-1:0]       ovl_token,
   output logic [NPAGE*WORD_W-1:0] ovl_bufs,
   output logic                    nak_zero,
   output logic                    wb_valid,
   output logic                    retire_valid,
   output logic [CERR_W-1:0]       retire_cerr
);
   localparam int BUF_W    = NPAGE * WORD_W;
   localparam int PTR_W    = WORD_W - LINK_LSB;
   localparam int TAG_BASE = 2 * WORD_W;

   generate
      if (NPAGE < 3 || NPAGE > 5) begin : g_bad_npage
         $error("qh_overlay_unit: NPAGE must lie in 3..5");
      end
      if (NAK_LSB + NAK_W != LINK_LSB) begin : g_bad_nak
         $error("qh_overlay_unit: NAK field must fill the link reserved bits");
      end
   endgenerate

   logic [WORD_W-1:0] tok_q, tok_new;
   logic [PTR_W-1:0]  next_ptr_q, alt_ptr_q;
   logic              next_t_q, alt_t_q;
   logic [BUF_W-1:0]  bufs_q, bufs_new;
   logic [NAK_W-1:0]  nak_cnt;
   logic              wb_q, ret_v_q;
   logic [CERR_W-1:0] ret_c_q;

   qho_token_merge #(.HS_EPS(HS_EPS)) u_tok (
      .cur_tok     (tok_q),
      .src_tok     (qtd_token),
      .dt_from_src (ep_dtc),
      .speed       (ep_eps),
      .new_tok     (tok_new)
   );

   for (genvar p = 0; p < NPAGE; p++) begin : g_page
      qho_page_merge #(.IDX(p)) u_page (
         .src_page (qtd_bufs[p*WORD_W +: WORD_W]),
         .new_page (bufs_new[p*WORD_W +: WORD_W])
      );
   end

   qho_nak_ctr u_nak (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovl_go    (ovl_go),
      .reload_go (list_restart),
      .nak_hit   (nak_resp),
      .rl        (ep_rl),
      .cnt       (nak_cnt),
      .zero      (nak_zero)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tok_q      <= '0;
         next_ptr_q <= '0;
         next_t_q   <= 1'b0;
         alt_ptr_q  <= '0;
         alt_t_q    <= 1'b0;
         bufs_q     <= '0;
         wb_q       <= 1'b0;
         ret_v_q    <= 1'b0;
         ret_c_q    <= '0;
      end else begin
         wb_q    <= ovl_go | list_restart | nak_resp;
         ret_v_q <= ovl_go;
         if (ovl_go) begin
            ret_c_q    <= tok_q[CERR_HI:CERR_LO];
            tok_q      <= tok_new;
            next_ptr_q <= qtd_next[WORD_W-1:LINK_LSB];
            next_t_q   <= qtd_next[0];
            alt_ptr_q  <= qtd_alt[WORD_W-1:LINK_LSB];
            alt_t_q    <= qtd_alt[0];
            bufs_q     <= bufs_new;
         end
      end
   end

   assign ovl_token    = tok_q;
   assign ovl_next     = {next_ptr_q, {NAK_W{1'b0}}, next_t_q};
   assign ovl_alt      = {alt_ptr_q, nak_cnt, alt_t_q};
   assign ovl_bufs     = bufs_q;
   assign wb_valid     = wb_q;
   assign retire_valid = ret_v_q;
   assign retire_cerr  = ret_c_q;

   assert_ioc_copy_R1: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_go |=> ovl_token[TOK_IOC] == $past(qtd_token[TOK_IOC]));
   assert_token_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_go |=> $stable(ovl_token));
   assert_dt_keep_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_go && !ep_dtc) |=> ovl_token[TOK_DT] == $past(ovl_token[TOK_DT]));
   assert_ping_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_go && ep_eps == HS_EPS) |=> ovl_token[TOK_PING] == $past(ovl_token[TOK_PING]));
   assert_tag_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_go |=> ovl_bufs[TAG_BASE +: TAG_W] == '0);
   assert_link_rsvd_R5: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_go |=> ovl_next[LINK_LSB-1:NAK_LSB] == '0);
   assert_retire_R10: assert property (@(posedge clk) disable iff (!rst_n)
      ovl_go |=> (retire_valid && retire_cerr == $past(ovl_token[CERR_HI:CERR_LO])));
   assert_retire_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !ovl_go |=> !retire_valid);
   assert_wb_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ovl_go || list_restart || nak_resp) |=> wb_valid);
   assert_wb_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
      !(ovl_go || list_restart || nak_resp) |=> !wb_valid);
endmodule

// File: tb/qh_overlay_unit_tb_top.sv
`timescale 1ns/1ps
module qh_overlay_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ovl_go = 1'b0, list_restart = 1'b0, nak_resp = 1'b0;
   logic [3:0]  ep_rl = '0;
   logic        ep_dtc = 1'b0;
   logic [1:0]  ep_eps = '0;
   logic [31:0] qtd_next = '0, qtd_alt = '0, qtd_token = '0;
   logic [95:0] qtd_bufs = '0;
   logic [31:0] ovl_next, ovl_alt, ovl_token;
   logic [95:0] ovl_bufs;
   logic        nak_zero, wb_valid, retire_valid;
   logic [1:0]  retire_cerr;

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   // reference state
   logic [31:0] m_next = '0, m_alt = '0, m_tok = '0;
   logic [95:0] m_bufs = '0;
   logic [3:0]  m_nak = '0;
   logic        m_wb = 1'b0, m_rv = 1'b0;
   logic [1:0]  m_rc = '0;
   string       nak_tag = "R6";

   always #2.5 clk = ~clk;

   qh_overlay_unit dut_i (
      .clk(clk), .rst_n(rst_n), .ovl_go(ovl_go), .list_restart(list_restart),
      .nak_resp(nak_resp), .ep_rl(ep_rl), .ep_dtc(ep_dtc), .ep_eps(ep_eps),
      .qtd_next(qtd_next), .qtd_alt(qtd_alt), .qtd_token(qtd_token),
      .qtd_bufs(qtd_bufs), .ovl_next(ovl_next), .ovl_alt(ovl_alt),
      .ovl_token(ovl_token), .ovl_bufs(ovl_bufs), .nak_zero(nak_zero),
      .wb_valid(wb_valid), .retire_valid(retire_valid), .retire_cerr(retire_cerr)
   );

   function automatic logic [31:0] exp_tok(logic [31:0] cur, logic [31:0] src,
                                           logic dtc, logic [1:0] eps);
      logic [31:0] r;
      r        = {1'b0, src[30:8], 8'h00};
      r[31]    = dtc ? src[31] : cur[31];
      r[0]     = (eps == 2'b10) ? cur[0] : src[0];
      return r;
   endfunction

   function automatic logic [95:0] exp_bufs(logic [95:0] src);
      logic [95:0] r;
      r[31:0]  = src[31:0];
      r[63:32] = {src[63:44], 12'h000};
      r[95:64] = {src[95:69], 5'h00};
      return r;
   endfunction

   task automatic chk(string tag, logic [95:0] act, logic [95:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic compare_all();
      chk("R1", {64'h0, ovl_token & 32'h7FFF_FFFE}, {64'h0, m_tok & 32'h7FFF_FFFE});
      chk("R2", {95'h0, ovl_token[31]}, {95'h0, m_tok[31]});
      chk("R3", {95'h0, ovl_token[0]}, {95'h0, m_tok[0]});
      chk("R4", ovl_bufs, m_bufs);
      chk("R5", {64'h0, ovl_next}, {64'h0, m_next});
      chk("R5", {64'h0, ovl_alt[31:5], ovl_alt[0]}, {64'h0, m_alt[31:5], m_alt[0]});
      chk(nak_tag, {92'h0, ovl_alt[4:1]}, {92'h0, m_nak});
      chk("R7", {95'h0, nak_zero}, {95'h0, (m_nak == 4'd0)});
      chk("R10", {95'h0, retire_valid}, {95'h0, m_rv});
      if (m_rv) chk("R10", {94'h0, retire_cerr}, {94'h0, m_rc});
      chk("R11", {95'h0, wb_valid}, {95'h0, m_wb});
   endtask

   // drive one cycle of stimulus at a negedge, advance the model, check at the next negedge
   task automatic step(logic go, logic rs, logic nk, logic [3:0] rl, logic dtc,
                       logic [1:0] eps, logic [31:0] nx, logic [31:0] al,
                       logic [31:0] tk, logic [95:0] bf);
      ovl_go = go; list_restart = rs; nak_resp = nk; ep_rl = rl; ep_dtc = dtc;
      ep_eps = eps; qtd_next = nx; qtd_alt = al; qtd_token = tk; qtd_bufs = bf;
      m_wb = go | rs | nk;
      m_rv = go;
      if (go) begin
         m_rc   = m_tok[11:10];
         m_tok  = exp_tok(m_tok, tk, dtc, eps);
         m_next = {nx[31:5], 4'h0, nx[0]};
         m_alt  = {al[31:5], 4'h0, al[0]};
         m_bufs = exp_bufs(bf);
         m_nak  = rl;
         nak_tag = (rs || nk) ? "R9" : "R5";
      end else if (rs) begin
         m_nak  = rl;
         nak_tag = "R8";
      end else begin
         if (nk && m_nak != 4'd0) m_nak = m_nak - 4'd1;
         nak_tag = "R6";
      end
      @(posedge clk);
      @(negedge clk);
      compare_all();
   endtask

   task automatic idle_nak(int n);
      for (int i = 0; i < n; i++)
         step(1'b0, 1'b0, 1'b1, 4'd0, 1'b0, 2'b00, '0, '0, '0, '0);
   endtask

   initial begin
      #1_000_000;
      if (!finished) begin
         n_fail++;
         n_chk++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20250611));
      repeat (4) @(negedge clk);
      // R12: reset state
      chk("R12", {ovl_next, ovl_alt, ovl_token}, 96'h0);
      chk("R12", ovl_bufs, 96'h0);
      chk("R12", {93'h0, nak_zero, wb_valid, retire_valid}, {93'h0, 3'b100});
      rst_n = 1'b1;
      @(negedge clk);
      compare_all();

      // directed: low-speed overlay sets ping and toggle, then high-speed keeps them (R2, R3)
      step(1'b1, 1'b0, 1'b0, 4'd2, 1'b1, 2'b01, 32'hAAAA_AA3F, 32'h5555_5561,
           32'h8000_8C01, {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h1234_5678});
      step(1'b1, 1'b0, 1'b0, 4'd2, 1'b0, 2'b10, 32'h0000_0020, 32'h0000_0001,
           32'h0000_0000, 96'h0);
      // R6: count down from 2, then saturate at zero
      idle_nak(4);
      // R9: overlay together with NAK and restart
      step(1'b1, 1'b1, 1'b1, 4'd7, 1'b1, 2'b00, 32'h1, 32'h1, 32'hFFFF_FFFF, '1);
      // R8: restart beats NAK
      step(1'b0, 1'b1, 1'b1, 4'd9, 1'b0, 2'b00, '0, '0, '0, '0);
      // R6: no strobe holds counter
      step(1'b0, 1'b0, 1'b0, 4'd3, 1'b1, 2'b10, '1, '1, '1, '1);

      // random mix
      for (int i = 0; i < 3000; i++) begin
         logic go, rs, nk;
         go = ($urandom % 4) == 0;
         rs = ($urandom % 7) == 0;
         nk = ($urandom % 5) < 2;
         step(go, rs, nk, 4'($urandom % 4), 1'($urandom), 2'($urandom),
              $urandom, $urandom, $urandom, {$urandom, $urandom, $urandom});
      end

      step(1'b0, 1'b0, 1'b0, '0, 1'b0, '0, '0, '0, '0, '0);
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule